// File: doc/BRIEF.md
# Dual-Port Interrupt-on-Change Controller

This block watches two 8-bit input ports. For each pin that is set as an input and has its interrupt enable set, it checks one of two conditions. The first is a change from the previously sampled value. The second is a mismatch against a programmed default value. When the first such event occurs on a port, the block sets that port's interrupt flag and stores a snapshot of the port value in a capture register. The snapshot and the flag then stay frozen until software clears the flag. Software clears it by completing a read of either the live-value register or the capture register of that port. A configuration bit chooses which of the two reads clears the flag.

The block has two interrupt lines, A and B. Each line either follows its own port, or, with mirroring on, follows the OR of both port flags. A line can be driven as push-pull active-low, push-pull active-high, or open-drain. Open-drain mode is represented as an output enable that is asserted only while the line pulls low, with the data output held at 0.

Software reaches the registers through a synchronous interface with four parts: a write strobe with address and data, a combinational read-data output, and a read-complete pulse. The clear happens only when the read-complete pulse arrives. Port pins pass through a two-flop synchronizer before they are compared.

Top module: `ioc_ctrl`

## Requirements
- R1: After reset no interrupt is pending, both lines are at their inactive level (push-pull active-low, so data 1 and enable 1), the direction registers read 8'hFF (all inputs), and enable, compare-mode, default, capture and config registers read 0.
- R2: A pin takes part in detection only when its direction bit is 1 (input) and its enable bit is 1. Other pins never set the port flag.
- R3: With compare-mode bit 0, a pin triggers when its synchronized value differs from the value sampled in the previous cycle. The flag, and its interrupt line, rises on the third rising clock edge after the pin changes.
- R4: With compare-mode bit 1, a pin triggers whenever its synchronized value differs from its default-register bit, even if the pin has not changed.
- R5: On the event that sets a port flag, the capture register takes the synchronized port value. While the flag stays set, further events change neither the capture register nor the flag.
- R6: Config bit 1 selects the clearing read: 0 selects the port's live register (offset 4), 1 selects its capture register (offset 5). A write to either register, a read of the other register, a read without the completion pulse, and a read of the other port all leave the flag set.
- R7: The clear takes effect on the clock edge that samples reg_rd_done_i high. Before that edge the line is still active.
- R8: If a qualifying condition is present on the clearing edge, the flag stays set and the capture register is loaded with the current port value on that edge.
- R9: Config bit 0 (mirror) makes both lines show the OR of the two port flags. A port flag is still cleared only by a read of that port's own register.
- R10: Config bit 3 selects active-high push-pull. Config bit 2 selects open-drain, which holds data at 0 and asserts the enable only while the line is active.
- R11: Offset 4 returns the synchronized port value. Port A uses addresses 0-7 and port B uses 8-15. Offsets: 0 direction, 1 enable, 2 compare mode, 3 default, 4 live, 5 capture, 7 config (shared). Writes to offsets 4 and 5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_a_i | input | 8 | Port A pins (asynchronous) |
| port_b_i | input | 8 | Port B pins (asynchronous) |
| reg_addr_i | input | 4 | Register address (bit 3 selects port) |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rd_done_i | input | 1 | Read-complete pulse for reg_addr_i |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| int_a_o | output | 1 | Interrupt line A data |
| int_a_oe_o | output | 1 | Interrupt line A output enable |
| int_b_o | output | 1 | Interrupt line B data |
| int_b_oe_o | output | 1 | Interrupt line B output enable |

## Verification
A directed sequence covers each corner on its own. Masked pins are changed to show that they are ignored. The flag's rise is timed to the exact edge. A later pin change checks that the snapshot stays frozen. Wrong-register reads, writes and completion-less reads are checked against the real clear, and a clear is done while a default mismatch persists so the re-fire shows. Random stimulus then mixes pin changes with writes to the direction, enable, mode and default registers, random config values, and read-complete pulses at random addresses. A bench model tracks flag, capture and previous value. This shows whether the change compare and the default compare hold the previous value correctly across pending intervals and clears under every mirror and drive mode.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

    // register offset within a port window
    localparam int IOC_OFS_W = 3;
    localparam int IOC_AW    = IOC_OFS_W + 1;
    localparam int IOC_NP    = 2;

    localparam logic [IOC_OFS_W-1:0] OFS_DIR  = 3'd0;
    localparam logic [IOC_OFS_W-1:0] OFS_IEN  = 3'd1;
    localparam logic [IOC_OFS_W-1:0] OFS_MODE = 3'd2;
    localparam logic [IOC_OFS_W-1:0] OFS_DEFV = 3'd3;
    localparam logic [IOC_OFS_W-1:0] OFS_LIVE = 3'd4;
    localparam logic [IOC_OFS_W-1:0] OFS_CAP  = 3'd5;
    localparam logic [IOC_OFS_W-1:0] OFS_CFG  = 3'd7;

    // shared configuration, bit 0 = mirror
    typedef struct packed {
        logic [3:0] rsvd;
        logic       act_high;
        logic       odrain;
        logic       clr_cap;
        logic       mirror;
    } ioc_cfg_t;

endpackage

// File: rtl/ioc_sync.sv
module ioc_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.s1 = d_i;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign q_o = s_q.s2;

endmodule

// File: rtl/ioc_port.sv
module ioc_port #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] ien_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] defv_i,
    input  logic         clr_i,
    output logic         flag_o,
    output logic [W-1:0] cap_o
);

    typedef struct packed {
        logic         flag;
        logic [W-1:0] cap;
        logic [W-1:0] prev;
    } port_t;

    port_t        s_d, s_q;
    logic [W-1:0] mask;
    logic [W-1:0] cmpv;
    logic [W-1:0] diff;
    logic         hit;

    always_comb begin
        mask = dir_i & ien_i;
        cmpv = (mode_i & defv_i) | (~mode_i & s_q.prev);
        diff = (pin_i ^ cmpv) & mask;
        hit  = |diff;

        s_d = s_q;
        if (clr_i) begin
            // clear, but re-arm at once if a condition is still there
            s_d.flag = hit;
            s_d.prev = pin_i;
            if (hit) begin
                s_d.cap = pin_i;
            end
        end else if (!s_q.flag) begin
            s_d.prev = pin_i;
            if (hit) begin
                s_d.flag = 1'b1;
                s_d.cap  = pin_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign flag_o = s_q.flag;
    assign cap_o  = s_q.cap;

    // R5: snapshot frozen while pending
    a_r5_cap_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.flag && !clr_i) |=> $stable(s_q.cap));

    // R5: snapshot equals port value on the setting edge
    a_r5_cap_on_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(s_q.flag) |-> (s_q.cap == $past(pin_i)));

    // R2: no qualifying pins means no new flag
    a_r2_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (((dir_i & ien_i) == '0) && !s_q.flag) |=> !s_q.flag);

    // R7: clear without pending condition drops the flag
    a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !hit) |=> !s_q.flag);

    // R8: clear with pending condition keeps the flag
    a_r8_refire: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && hit) |=> s_q.flag);

endmodule

// File: rtl/ioc_outdrv.sv
module ioc_outdrv (
    input  logic [1:0] flag_i,
    input  logic       mirror_i,
    input  logic       odrain_i,
    input  logic       act_high_i,
    output logic [1:0] int_o,
    output logic [1:0] int_oe_o
);

    logic [1:0] act;

    for (genvar g = 0; g < 2; g++) begin : g_line
        assign act[g]      = mirror_i ? (|flag_i) : flag_i[g];
        assign int_o[g]    = odrain_i ? 1'b0 : (act_high_i ? act[g] : ~act[g]);
        assign int_oe_o[g] = odrain_i ? act[g] : 1'b1;
    end

endmodule

// File: rtl/ioc_ctrl.sv
module ioc_ctrl
    import ioc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [W-1:0]      port_a_i,
    input  logic [W-1:0]      port_b_i,
    input  logic [IOC_AW-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [W-1:0]      reg_wdata_i,
    input  logic              reg_rd_done_i,
    output logic [W-1:0]      reg_rdata_o,
    output logic              int_a_o,
    output logic              int_a_oe_o,
    output logic              int_b_o,
    output logic              int_b_oe_o
);

    localparam int NP = IOC_NP;

    typedef struct packed {
        logic [NP-1:0][W-1:0] dir;
        logic [NP-1:0][W-1:0] ien;
        logic [NP-1:0][W-1:0] mode;
        logic [NP-1:0][W-1:0] defv;
        ioc_cfg_t             cfg;
    } regs_t;

    regs_t                r_d, r_q;
    logic [NP-1:0][W-1:0] pin_raw;
    logic [NP-1:0][W-1:0] pin_s;
    logic [NP-1:0][W-1:0] cap;
    logic [NP-1:0]        flag;
    logic [NP-1:0]        clr;
    logic [1:0]           int_o;
    logic [1:0]           int_oe;
    logic                 psel;
    logic [IOC_OFS_W-1:0] ofs;
    logic [IOC_OFS_W-1:0] clr_ofs;

    assign pin_raw = {port_b_i, port_a_i};
    assign psel    = reg_addr_i[IOC_AW-1];
    assign ofs     = reg_addr_i[IOC_OFS_W-1:0];
    assign clr_ofs = r_q.cfg.clr_cap ? OFS_CAP : OFS_LIVE;

    // register writes
    always_comb begin
        r_d = r_q;
        if (reg_wr_i) begin
            case (ofs)
                OFS_DIR:  r_d.dir[psel]  = reg_wdata_i;
                OFS_IEN:  r_d.ien[psel]  = reg_wdata_i;
                OFS_MODE: r_d.mode[psel] = reg_wdata_i;
                OFS_DEFV: r_d.defv[psel] = reg_wdata_i;
                OFS_CFG:  r_d.cfg        = ioc_cfg_t'(reg_wdata_i[7:0]);
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.dir  <= '1;
            r_q.ien  <= '0;
            r_q.mode <= '0;
            r_q.defv <= '0;
            r_q.cfg  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // register reads
    always_comb begin
        case (ofs)
            OFS_DIR:  reg_rdata_o = r_q.dir[psel];
            OFS_IEN:  reg_rdata_o = r_q.ien[psel];
            OFS_MODE: reg_rdata_o = r_q.mode[psel];
            OFS_DEFV: reg_rdata_o = r_q.defv[psel];
            OFS_LIVE: reg_rdata_o = pin_s[psel];
            OFS_CAP:  reg_rdata_o = cap[psel];
            OFS_CFG:  reg_rdata_o = W'(r_q.cfg);
            default:  reg_rdata_o = '0;
        endcase
    end

    for (genvar g = 0; g < NP; g++) begin : g_port
        assign clr[g] = reg_rd_done_i && (psel == 1'(g)) && (ofs == clr_ofs);

        ioc_sync #(.W(W)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (pin_raw[g]),
            .q_o    (pin_s[g])
        );

        ioc_port #(.W(W)) u_port (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pin_i  (pin_s[g]),
            .dir_i  (r_q.dir[g]),
            .ien_i  (r_q.ien[g]),
            .mode_i (r_q.mode[g]),
            .defv_i (r_q.defv[g]),
            .clr_i  (clr[g]),
            .flag_o (flag[g]),
            .cap_o  (cap[g])
        );
    end

    ioc_outdrv u_outdrv (
        .flag_i     (flag),
        .mirror_i   (r_q.cfg.mirror),
        .odrain_i   (r_q.cfg.odrain),
        .act_high_i (r_q.cfg.act_high),
        .int_o      (int_o),
        .int_oe_o   (int_oe)
    );

    assign int_a_o    = int_o[0];
    assign int_b_o    = int_o[1];
    assign int_a_oe_o = int_oe[0];
    assign int_b_oe_o = int_oe[1];

    // R9: mirrored lines agree
    a_r9_mirror_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cfg.mirror |-> ((int_a_o == int_b_o) && (int_a_oe_o == int_b_oe_o)));

    // R10: open-drain never drives high
    a_r10_od_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.cfg.odrain |-> (!int_a_o && !int_b_o));

    // R6: a write never clears a pending port A flag
    a_r6_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && !reg_rd_done_i && flag[0]) |=> flag[0]);

    // R9: only port B's own read clears port B
    a_r9_own_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag[1] && !clr[1]) |=> flag[1]);

endmodule

// File: tb/ioc_ctrl_tb.sv
module ioc_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pa = '0, pb = '0;
    logic [3:0] addr = '0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_done = 1'b0;
    logic [7:0] rdata;
    logic       ia, ia_oe, ib, ib_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // bench model
    logic [7:0] m_dir[2], m_ien[2], m_mode[2], m_defv[2];
    logic [7:0] m_prev[2], m_cap[2], m_pin[2];
    logic       m_flag[2];
    logic [7:0] m_cfg;

    always #10 clk = ~clk;

    ioc_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .port_a_i(pa), .port_b_i(pb),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rd_done_i(rd_done), .reg_rdata_o(rdata),
        .int_a_o(ia), .int_a_oe_o(ia_oe), .int_b_o(ib), .int_b_oe_o(ib_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_lines();
        logic [1:0] act;
        logic [3:0] r;
        act[0] = m_cfg[0] ? (m_flag[0] | m_flag[1]) : m_flag[0];
        act[1] = m_cfg[0] ? (m_flag[0] | m_flag[1]) : m_flag[1];
        for (int i = 0; i < 2; i++) begin
            logic o, oe;
            o  = m_cfg[2] ? 1'b0 : (m_cfg[3] ? act[i] : ~act[i]);
            oe = m_cfg[2] ? act[i] : 1'b1;
            r[3-2*i -: 2] = {o, oe};
        end
        return r;
    endfunction

    function automatic logic model_hit(input int p);
        logic [7:0] cmpv;
        cmpv = (m_mode[p] & m_defv[p]) | (~m_mode[p] & m_prev[p]);
        return |((m_pin[p] ^ cmpv) & m_dir[p] & m_ien[p]);
    endfunction

    task automatic model_step();
        for (int p = 0; p < 2; p++) begin
            if (!m_flag[p]) begin
                if (model_hit(p)) begin
                    m_flag[p] = 1'b1;
                    m_cap[p]  = m_pin[p];
                end
                m_prev[p] = m_pin[p];
            end
        end
    endtask

    task automatic model_clear(input int p);
        logic h;
        h = model_hit(p);
        m_flag[p] = h;
        if (h) m_cap[p] = m_pin[p];
        m_prev[p] = m_pin[p];
    endtask

    task automatic check_all(input string tag);
        logic [3:0] a;
        a = {ia, ia_oe, ib, ib_oe};
        chk(tag, {4'h0, a}, {4'h0, exp_lines()});
        addr = 4'd5; #1;
        chk(tag, rdata, m_cap[0]);
        addr = 4'd13; #1;
        chk(tag, rdata, m_cap[1]);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        model_step();
    endtask

    task automatic set_pin(input int p, input logic [7:0] v);
        @(negedge clk);
        if (p == 0) pa = v; else pb = v;
        m_pin[p] = v;
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        int p;
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        p = a[3];
        case (a[2:0])
            3'd0: m_dir[p]  = d;
            3'd1: m_ien[p]  = d;
            3'd2: m_mode[p] = d;
            3'd3: m_defv[p] = d;
            3'd7: m_cfg     = d;
            default: ;
        endcase
        settle();
    endtask

    task automatic read_done(input logic [3:0] a);
        int p;
        @(negedge clk);
        addr = a; rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        p = a[3];
        if (a[2:0] == (m_cfg[1] ? 3'd5 : 3'd4)) model_clear(p);
        settle();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd7719);
        for (int p = 0; p < 2; p++) begin
            m_dir[p] = 8'hFF; m_ien[p] = '0; m_mode[p] = '0; m_defv[p] = '0;
            m_prev[p] = '0; m_cap[p] = '0; m_pin[p] = '0; m_flag[p] = 1'b0;
        end
        m_cfg = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 lines", {4'h0, ia, ia_oe, ib, ib_oe}, 8'h0F);
        addr = 4'd0;  #1; chk("R1 dir A", rdata, 8'hFF);
        addr = 4'd9;  #1; chk("R1 ien B", rdata, 8'h00);
        addr = 4'd7;  #1; chk("R1 cfg", rdata, 8'h00);
        addr = 4'd5;  #1; chk("R1 cap A", rdata, 8'h00);

        // R11 live value read, R2 nothing enabled
        set_pin(0, 8'h5A); settle();
        addr = 4'd4; #1; chk("R11 live A", rdata, 8'h5A);
        check_all("R2 not enabled");

        // R2 outputs masked by direction, disabled by enable
        reg_write(4'd0, 8'h0F);
        reg_write(4'd1, 8'hF0);
        set_pin(0, 8'hA5); settle();
        check_all("R2 masked pins");

        // R3 latency: flag on third edge
        reg_write(4'd0, 8'hFF);
        reg_write(4'd1, 8'hFF);
        set_pin(0, 8'hA4);
        repeat (2) @(negedge clk);
        chk("R3 not before third edge", {7'h0, ia}, 8'h01);
        @(negedge clk);
        chk("R3 active on third edge", {7'h0, ia}, 8'h00);
        model_step();
        check_all("R3 change fire");

        // R5 frozen snapshot
        set_pin(0, 8'h00); settle();
        check_all("R5 frozen");

        // R6 write, wrong register, wrong port do not clear
        reg_write(4'd4, 8'h00);
        reg_write(4'd5, 8'h00);
        check_all("R6 writes ignored");
        read_done(4'd5);
        check_all("R6 capture read with live select");
        read_done(4'd12);
        check_all("R6 other port read");
        addr = 4'd4; #1; @(negedge clk); @(negedge clk);
        check_all("R6 read without completion");

        // R7 clear timing
        set_pin(0, 8'hA4); settle();
        @(negedge clk);
        addr = 4'd4; rd_done = 1'b1; #1;
        chk("R7 still active before edge", {7'h0, ia}, 8'h00);
        @(negedge clk);
        rd_done = 1'b0;
        chk("R7 cleared after edge", {7'h0, ia}, 8'h01);
        model_clear(0);
        settle();
        check_all("R7 cleared");

        // R4 default compare, R8 re-fire with recapture
        reg_write(4'd3, 8'hA4);
        reg_write(4'd2, 8'hFF);
        check_all("R4 equal default quiet");
        set_pin(0, 8'h00); settle();
        check_all("R4 default mismatch");
        set_pin(0, 8'h11); settle();
        read_done(4'd4);
        check_all("R8 refire recapture");
        addr = 4'd5; #1; chk("R8 capture new value", rdata, 8'h11);

        // R9 mirror
        set_pin(0, 8'hA4); settle();
        read_done(4'd4);
        check_all("R9 A clear");
        reg_write(4'd9, 8'h01);
        reg_write(4'd7, 8'h01);
        set_pin(1, 8'h01); settle();
        check_all("R9 mirrored B");
        read_done(4'd4);
        check_all("R9 A read keeps B");
        read_done(4'd12);
        check_all("R9 B cleared");

        // R10 drive modes, R6 capture select
        reg_write(4'd7, 8'h0A);
        check_all("R10 active-high idle");
        set_pin(1, 8'h00); settle();
        check_all("R10 active-high set");
        read_done(4'd12);
        check_all("R6 live read with capture select");
        reg_write(4'd7, 8'h06);
        check_all("R10 open-drain active");
        read_done(4'd13);
        check_all("R6 capture read clears");

        // random phase
        for (int it = 0; it < 400; it++) begin
            int unsigned r;
            int p;
            r = $urandom % 8;
            p = $urandom % 2;
            case (r)
                0, 1: set_pin(p, 8'($urandom));
                2:    set_pin(p, m_pin[p] ^ (8'h01 << ($urandom % 8)));
                3:    reg_write({1'(p), 3'($urandom % 4)}, 8'($urandom));
                4:    reg_write(4'd7, 8'($urandom));
                5, 6: read_done({1'(p), 3'($urandom % 8)});
                default: reg_write({1'(p), 3'd4 + 3'($urandom % 2)}, 8'($urandom));
            endcase
            if (r < 3) settle();
            check_all("R3 R4 R5 R6 R8 R9 R10 random");
        end

        finished = 1;
        report();
    end

endmodule